// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave side of a host control port. It holds eight 8-bit registers and lets a host reach them either over a three-wire serial scheme or over an 8-bit parallel bus. The choice between them is strapped. In serial mode the host writes a register by clocking eight data bits in on the serial data line, least significant bit first, and then pulsing the write strobe. The register is loaded when the strobe goes high again. To read, the host pulls the read strobe low. That loads the addressed register into the shifter and puts bit 0 on the serial data line. Each falling shift-clock edge then advances to the next bit.

The shift clock and both strobes are asynchronous to the system clock. Each one passes through a two-flop synchronizer and an edge-detect flop, so the block acts on the third system clock edge after a pin changes. Address and data pins are sampled directly on that edge, so the host holds them steady across the strobe. The serial data pin is modelled as separate input, output and per-bit output-enable vectors over the 8-bit bus. Bit 7 of the bus carries serial data, and bits 2:0 carry the register address.

The serial engine is a three-state machine:
- `ST_IDLE` moves to `ST_WR_SHIFT` on a shift-clock fall, and to `ST_RD_SHIFT` on a read-strobe fall.
- `ST_WR_SHIFT` moves to `ST_IDLE` on a write-strobe rise, which commits the shifter. It moves to `ST_RD_SHIFT` on a read-strobe fall.
- `ST_RD_SHIFT` moves back to `ST_IDLE` on a read-strobe rise.

Top module: `serial_reg_port`

## Requirements
- R1: After reset every register reads zero, the bit counter is 0 and no bus bit is driven (output enable all zero).
- R2: Mode is sampled on the first clock after reset release: serial when `ale_i` is high and `cs_n_i` low, parallel otherwise, and held until the next reset. In parallel mode shift-clock edges leave the bit counter at 0.
- R3: Serial write: each synchronized shift-clock fall with read strobe high shifts `bus_i[7]` into bit 7 of the shifter while its contents move one place toward bit 0. A write-strobe rise copies the shifter into the register at `bus_i[2:0]` and clears the bit counter.
- R4: A write-strobe rise after fewer than eight shift edges still commits the shifter as it stands. The shifter keeps its contents across commits, so its older bits fill the positions not yet shifted.
- R5: Serial read: a read-strobe fall loads the register at `bus_i[2:0]` into the shifter, clears the bit counter, drives bit 0 on `bus_o[7]` with `bus_oe_o` = 8'h80. Each later shift-clock fall moves the next bit, LSB first, onto `bus_o[7]`. Zeros follow once all eight bits are out.
- R6: No bus bit is driven unless a read is active. `bus_oe_o` is only ever 8'h00, 8'h80 or 8'hFF, and it returns to 8'h00 once the read strobe rises.
- R7: `bit_cnt_o` counts shift-clock falls within a transfer and saturates at 8. It clears on a commit, at the start of a read and at its end.
- R8: Parallel write: a write-strobe rise stores `bus_i[7:0]` into the latched address only when the latched chip select is low. With it latched high the write has no effect.
- R9: Parallel read: while the synchronized read strobe and the latched chip select are both low, `bus_oe_o` is 8'hFF and `bus_o` shows the register at the latched address.
- R10: While `ale_i` is high the address (`bus_i[2:0]`) and `cs_n_i` are captured every clock. While it is low they hold, whatever the bus carries.
- R11: Every strobe and shift-clock change takes effect on the third rising clock edge after the pin changes. All outputs follow cycle-exactly from that rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch enable; mode strap together with `cs_n_i` |
| cs_n_i | input | 1 | Active-low chip select; mode strap |
| sclk_i | input | 1 | External shift clock (asynchronous) |
| rd_n_i | input | 1 | Active-low read strobe (asynchronous) |
| wr_n_i | input | 1 | Active-low write strobe (asynchronous) |
| bus_i | input | 8 | Bus pins as seen by the block: bit 7 serial data in, bits 2:0 address |
| bus_o | output | 8 | Bus pins driven by the block |
| bus_oe_o | output | 8 | Per-bit output enable for `bus_o` |
| bit_cnt_o | output | 4 | Shift-edge counter, exposed for test |

## Verification
The bench targets four failure modes:
- **Partial write.** A block that zeroed the shifter, or that committed only after a full byte, would store the wrong value or nothing at all.
- **Read past the last bit.** A counter that did not saturate would wrap past eight when extra shift edges arrive during a read.
- **Strobe-driven release.** A block that released the bus on anything other than the read strobe would keep driving after the strobe rises.
- **Gated parallel write.** A write taken with chip select latched high would overwrite a register. If the latch followed the bus while ALE is low, the read would come from the wrong address.

A cycle-exact model also catches any block whose synchronizer depth or edge priority differs from the stated three-edge latency.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WR_SHIFT = 2'd1,
        ST_RD_SHIFT = 2'd2
    } srp_state_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] dly_o
);
    logic [N-1:0] pipe_q [STAGES];
    logic [N-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '1;
            dly_q <= '1;
        end else begin
            pipe_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            dly_q <= pipe_q[STAGES-1];
        end
    end

    assign lvl_o = pipe_q[STAGES-1];
    assign dly_o = dly_q;
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] bus_oe_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam int IDX_RD = 0;
    localparam int IDX_WR = 1;
    localparam int IDX_SC = 2;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

    // Synchronized strobes and edges
    logic [2:0] sync_lvl, sync_dly;
    srp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sclk_i, wr_n_i, rd_n_i}),
        .lvl_o (sync_lvl),
        .dly_o (sync_dly)
    );

    logic rd_fall, rd_rise, wr_rise, sclk_fall, rd_dly_n;
    assign rd_fall   =  sync_dly[IDX_RD] & ~sync_lvl[IDX_RD];
    assign rd_rise   = ~sync_dly[IDX_RD] &  sync_lvl[IDX_RD];
    assign wr_rise   = ~sync_dly[IDX_WR] &  sync_lvl[IDX_WR];
    assign sclk_fall =  sync_dly[IDX_SC] & ~sync_lvl[IDX_SC];
    assign rd_dly_n  =  sync_dly[IDX_RD];

    // Mode strap, captured once after reset release
    logic serial_mode, strap_done;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serial_mode <= 1'b0;
            strap_done  <= 1'b0;
        end else if (!strap_done) begin
            serial_mode <= ale_i & ~cs_n_i;
            strap_done  <= 1'b1;
        end
    end

    // Address / chip-select latch for parallel access
    logic [ADDR_W-1:0] addr_q;
    logic              cs_n_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cs_n_q <= 1'b1;
        end else if (ale_i) begin
            addr_q <= bus_i[ADDR_W-1:0];
            cs_n_q <= cs_n_i;
        end
    end

    // State machine
    srp_state_e        state_q, state_d;
    logic [DATA_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              in_rd_shift, do_commit;

    assign in_rd_shift = (state_q == ST_RD_SHIFT);
    assign do_commit   = serial_mode && !in_rd_shift && !rd_fall && wr_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (serial_mode) begin
            unique case (state_q)
                ST_IDLE, ST_WR_SHIFT: begin
                    if (rd_fall)        state_d = ST_RD_SHIFT;
                    else if (wr_rise)   state_d = ST_IDLE;
                    else if (sclk_fall) state_d = ST_WR_SHIFT;
                end
                ST_RD_SHIFT: begin
                    if (rd_rise)        state_d = ST_IDLE;
                end
                default:                state_d = ST_IDLE;
            endcase
        end
    end

    // Register bank
    logic [ADDR_W-1:0] bank_addr;
    logic [DATA_W-1:0] bank_rdata, bank_wdata;
    logic              bank_we;

    assign bank_addr  = serial_mode ? bus_i[ADDR_W-1:0] : addr_q;
    assign bank_wdata = serial_mode ? shift_q : bus_i;
    assign bank_we    = do_commit || (!serial_mode && wr_rise && !cs_n_q);

    srp_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bank_we),
        .addr_i  (bank_addr),
        .wdata_i (bank_wdata),
        .rdata_o (bank_rdata)
    );

    // Shifter and bit counter
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (serial_mode) begin
            unique case (state_q)
                ST_IDLE, ST_WR_SHIFT: begin
                    if (rd_fall) begin
                        shift_q <= bank_rdata;
                        cnt_q   <= '0;
                    end else if (wr_rise) begin
                        cnt_q   <= '0;
                    end else if (sclk_fall) begin
                        shift_q <= {bus_i[DATA_W-1], shift_q[DATA_W-1:1]};
                        cnt_q   <= cnt_inc;
                    end
                end
                ST_RD_SHIFT: begin
                    if (rd_rise) begin
                        cnt_q   <= '0;
                    end else if (sclk_fall) begin
                        shift_q <= shift_q >> 1;
                        cnt_q   <= cnt_inc;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Bus drive
    always_comb begin
        bus_o    = '0;
        bus_oe_o = '0;
        if (serial_mode) begin
            if (in_rd_shift) begin
                bus_o[DATA_W-1]    = shift_q[0];
                bus_oe_o[DATA_W-1] = 1'b1;
            end
        end else if (!rd_dly_n && !cs_n_q) begin
            bus_o    = bank_rdata;
            bus_oe_o = '1;
        end
    end

    assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              serial_mode,
    input logic              rd_fall,
    input logic              wr_rise,
    input logic              rd_dly_n,
    input logic              in_rd_shift,
    input logic [DATA_W-1:0] bus_oe_o,
    input logic [CNT_W-1:0]  bit_cnt_o
);
    localparam logic [DATA_W-1:0] OE_SER = {1'b1, {(DATA_W-1){1'b0}}};

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> serial_mode);

    assert_commit_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && wr_rise && !rd_fall && !in_rd_shift) |=> (bit_cnt_o == '0));

    assert_read_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && rd_fall) |=> (bus_oe_o == OE_SER && bit_cnt_o == '0));

    assert_oe_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o == '0) || (bus_oe_o == OE_SER) || (bus_oe_o == '1));

    assert_oe_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_oe_o) |-> !rd_dly_n);

    assert_cnt_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_o <= CNT_W'(DATA_W));
endmodule

bind serial_reg_port srp_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .serial_mode (serial_mode),
    .rd_fall     (rd_fall),
    .wr_rise     (wr_rise),
    .rd_dly_n    (rd_dly_n),
    .in_rd_shift (in_rd_shift),
    .bus_oe_o    (bus_oe_o),
    .bit_cnt_o   (bit_cnt_o)
);

// File: tb/serial_reg_port_tb.sv
`timescale 1ns/1ps
module serial_reg_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale_i = 1'b1, cs_n_i = 1'b0;
    logic       sclk_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1;
    logic [7:0] bus_i = 8'h00;
    logic [7:0] bus_o, bus_oe_o;
    logic [3:0] bit_cnt_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .cs_n_i(cs_n_i),
        .sclk_i(sclk_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .bus_i(bus_i),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .bit_cnt_o(bit_cnt_o)
    );

    // Behavioural reference: pin history, three-edge latency
    int m_regs [8];
    int m_sh, m_cnt, m_state, m_addr;
    bit m_mode, m_done, m_cs;
    bit hs [4], hr [4], hw [4];
    int e_oe, e_bus, e_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = 0;
            m_sh = 0; m_cnt = 0; m_state = 0; m_addr = 0;
            m_mode = 0; m_done = 0; m_cs = 1;
            for (int i = 0; i < 4; i++) begin hs[i] = 1; hr[i] = 1; hw[i] = 1; end
        end else begin
            bit rdf, rdr, wrr, scf;
            rdf = hr[2] && !hr[1];
            rdr = !hr[2] && hr[1];
            wrr = !hw[2] && hw[1];
            scf = hs[2] && !hs[1];
            if (m_mode) begin
                if (m_state == 2) begin
                    if (rdr) begin m_state = 0; m_cnt = 0; end
                    else if (scf) begin
                        m_sh = m_sh / 2;
                        if (m_cnt < 8) m_cnt++;
                    end
                end else begin
                    if (rdf) begin
                        m_state = 2; m_sh = m_regs[bus_i[2:0]]; m_cnt = 0;
                    end else if (wrr) begin
                        m_regs[bus_i[2:0]] = m_sh; m_cnt = 0; m_state = 0;
                    end else if (scf) begin
                        m_sh = m_sh / 2 + (bus_i[7] ? 128 : 0);
                        if (m_cnt < 8) m_cnt++;
                        m_state = 1;
                    end
                end
            end else if (wrr && !m_cs) begin
                m_regs[m_addr] = bus_i;
            end
            if (ale_i) begin m_addr = bus_i[2:0]; m_cs = cs_n_i; end
            if (!m_done) begin m_mode = ale_i && !cs_n_i; m_done = 1; end
            for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hr[i] = hr[i-1]; hw[i] = hw[i-1]; end
            hs[0] = sclk_i; hr[0] = rd_n_i; hw[0] = wr_n_i;
        end
        e_oe = 0; e_bus = 0; e_cnt = m_cnt;
        if (m_mode && m_state == 2) begin
            e_oe = 8'h80; e_bus = (m_sh % 2) ? 8'h80 : 0;
        end else if (!m_mode && !hr[2] && !m_cs) begin
            e_oe = 8'hFF; e_bus = m_regs[m_addr];
        end
    end

    // Per-clock comparison (R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (int'(bus_oe_o) != e_oe || int'(bit_cnt_o) != e_cnt ||
                (e_oe != 0 && int'(bus_o & bus_oe_o) != e_bus)) begin
                n_bad++;
                $display("FAIL R11 t=%0t oe/bus/cnt act %h/%h/%0d exp %h/%h/%0d",
                         $time, bus_oe_o, bus_o & bus_oe_o, bit_cnt_o, e_oe, e_bus, e_cnt);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(bit b);
        bus_i[7] = b; sclk_i = 1'b1; tick(4);
        sclk_i = 1'b0; tick(4);
    endtask

    task automatic ser_write(int addr, int data, int nbits);
        bus_i[2:0] = addr[2:0];
        for (int i = 0; i < nbits; i++) ser_bit(data[i]);
        sclk_i = 1'b1; tick(4);
        wr_n_i = 1'b0; tick(4);
        wr_n_i = 1'b1; tick(5);
    endtask

    task automatic ser_read(int addr, output int val);
        val = 0;
        bus_i[2:0] = addr[2:0];
        rd_n_i = 1'b0; tick(5);
        chk("R5 oe during serial read", bus_oe_o, 8'h80);
        for (int i = 0; i < 8; i++) begin
            if (bus_o[7]) val |= (1 << i);
            sclk_i = 1'b0; tick(4);
            sclk_i = 1'b1; tick(4);
        end
        chk("R7 count after eight read edges", bit_cnt_o, 8);
        rd_n_i = 1'b1; tick(5);
        chk("R6 bus released after read", bus_oe_o, 0);
    endtask

    task automatic par_write(int addr, int data, bit cs);
        ale_i = 1'b1; cs_n_i = cs; bus_i = addr[7:0]; tick(2);
        ale_i = 1'b0; cs_n_i = 1'b1; bus_i = data[7:0];
        wr_n_i = 1'b0; tick(4);
        wr_n_i = 1'b1; tick(5);
    endtask

    int v;

    initial begin
        tick(4);
        rst_n = 1'b1; tick(3);
        chk("R1 count after reset", bit_cnt_o, 0);
        chk("R1 oe after reset", bus_oe_o, 0);
        ser_read(0, v); chk("R1 reg0 after reset", v, 0);
        ser_read(7, v); chk("R1 reg7 after reset", v, 0);

        ser_write(3, 8'hA5, 8);
        chk("R3 count cleared by commit", bit_cnt_o, 0);
        ser_write(5, 8'h05, 3);   // bits 1,0,1 onto 0xA5 -> 0xB4
        ser_read(3, v); chk("R3 full write readback", v, 8'hA5);
        ser_read(5, v); chk("R4 partial write readback", v, 8'hB4);

        // R7 saturation with extra read edges
        bus_i[2:0] = 3'd3; rd_n_i = 1'b0; tick(5);
        for (int i = 0; i < 10; i++) begin
            sclk_i = 1'b0; tick(4); sclk_i = 1'b1; tick(4);
        end
        chk("R7 count saturates", bit_cnt_o, 8);
        chk("R5 zeros after last bit", bus_o[7], 0);
        rd_n_i = 1'b1; tick(5);
        chk("R7 count cleared at read end", bit_cnt_o, 0);

        // Parallel mode
        ale_i = 1'b0; cs_n_i = 1'b1; rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(3);
        sclk_i = 1'b0; tick(4); sclk_i = 1'b1; tick(4);
        chk("R2 shift clock ignored in parallel mode", bit_cnt_o, 0);
        par_write(6, 8'h3C, 1'b0);
        par_write(6, 8'h77, 1'b1);
        ale_i = 1'b1; cs_n_i = 1'b0; bus_i = 8'h06; tick(2);
        ale_i = 1'b0; cs_n_i = 1'b1; bus_i = 8'h01;
        rd_n_i = 1'b0; tick(4);
        chk("R9 parallel oe", bus_oe_o, 8'hFF);
        chk("R8 write with cs high ignored", bus_o, 8'h3C);
        chk("R10 latch holds address", bus_o, 8'h3C);
        rd_n_i = 1'b1; tick(5);
        chk("R6 parallel bus released", bus_oe_o, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        done = 1'b1;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule